// File: doc/BRIEF.md
# GPIO Interrupt Trigger Detector

This block watches sixteen general-purpose input pins and turns activity on them into per-line interrupt requests for a downstream interrupt controller. Each line has its own 3-bit trigger style: level high, level low, rising edge, falling edge, or either edge. Any other code switches detection off for that line. The styles of the lower eight lines live in one configuration word, and those of the upper eight lines in a second word. Pins are synchronised by two flops before any detection takes place.

Detected events set a pending bit, and each pending bit drives that line's interrupt output directly. Software reads the pending bits through a small register port and clears them by writing ones. A level-style pending bit cannot be cleared while its pin still holds the active level. Changing a line's style clears that line's pending bit, so stale events from the old style are never reported.

Top module: `gpio_irq_detect`

## Requirements
- R1: Style codes behave as follows. Code 0 sets pending while the synchronised pin is 1. Code 1 sets pending while it is 0. Code 2 sets pending on a 0-to-1 change. Code 3 sets pending on a 1-to-0 change. Code 4 sets pending on either change.
- R2: Register addresses are: 0 holds the styles of lines 0..7, 1 holds the styles of lines 8..15, and 2 holds the pending bits in bits 15:0. Line n's style field occupies bits [3*(n mod 8) +: 3] of its register. Reads return 0 in bits that are not used.
- R3: Writing address 2 clears the pending bit of every line whose data bit is 1. Data bits of 0 leave pending bits unchanged.
- R4: On a line with a level style, a clear request leaves the pending bit set while the pin still holds the active level. Once the pin leaves the active level, the clear request takes effect.
- R5: A style-register write that changes a line's field clears that line's pending bit on the same clock edge.
- R6: An edge-style pending bit stays set after the pin returns to its idle level, until software clears it.
- R7: irq_o equals the pending bits. After reset, every style field reads 7 and every pending bit is 0.
- R8: Codes 5, 6 and 7 never set a pending bit.
- R9: A pin change first shows on irq_o after the third rising clock edge, counted from the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 16 | Asynchronous GPIO inputs |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| irq_o | output | 16 | Per-line interrupt requests |

## Verification
A corrupted pending bit shows at irq_o on the clock edge right after the fault, because the outputs are the pending flops themselves. A wrong style field shows only when the pin makes a matching change, about three edges later. For this reason the bench drives every style through both pin directions. A misplaced field shows as the wrong line firing, or as a readback mismatch on the style word. A faulty clear rule shows on the edge after the status write, as a bit that survives or vanishes when it should not.

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int LINES = 16,
  parameter int FW    = 3,
  parameter int AW    = 2,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pin_i,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic [LINES-1:0] irq_o
);
  localparam int HALF = LINES / 2;
  localparam int SW   = HALF * FW;

  logic [SW-1:0]    sty_lo, sty_hi;
  logic [LINES-1:0] s1, s2, prev, pend, det, restyle, clr;

  wire wr_lo = wr_en && (addr == AW'(0));
  wire wr_hi = wr_en && (addr == AW'(1));
  wire wr_st = wr_en && (addr == AW'(2));
  assign clr = wr_st ? wdata[LINES-1:0] : '0;

  function automatic logic hit(input logic [FW-1:0] code, input logic cur, input logic old);
    case (code)
      FW'(0):  hit = cur;
      FW'(1):  hit = !cur;
      FW'(2):  hit = cur && !old;
      FW'(3):  hit = !cur && old;
      FW'(4):  hit = cur ^ old;
      default: hit = 1'b0;
    endcase
  endfunction

  for (genvar i = 0; i < LINES; i++) begin : g_line
    localparam int OFF = (i % HALF) * FW;
    logic [FW-1:0] code;
    logic          mine;
    if (i < HALF) begin : g_lo
      assign code = sty_lo[OFF +: FW];
      assign mine = wr_lo;
    end else begin : g_hi
      assign code = sty_hi[OFF +: FW];
      assign mine = wr_hi;
    end
    assign restyle[i] = mine && (wdata[OFF +: FW] != code);
    assign det[i]     = hit(code, s2[i], prev[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1     <= '0;
      s2     <= '0;
      prev   <= '0;
      pend   <= '0;
      sty_lo <= '1;
      sty_hi <= '1;
    end else begin
      s1   <= pin_i;
      s2   <= s1;
      prev <= s2;
      pend <= ((pend & ~clr) | det) & ~restyle;
      if (wr_lo) sty_lo <= wdata[SW-1:0];
      if (wr_hi) sty_hi <= wdata[SW-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(0):  rdata[SW-1:0]    = sty_lo;
      AW'(1):  rdata[SW-1:0]    = sty_hi;
      AW'(2):  rdata[LINES-1:0] = pend;
      default: rdata = '0;
    endcase
  end

  assign irq_o = pend;

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(det)) == '0)); // R1
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_st |=> ((pend & $past(clr & ~det)) == '0)); // R3
  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (det != '0) |=> ((pend & $past(det & ~restyle)) == $past(det & ~restyle))); // R4
  AST_RESTYLE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (restyle != '0) |=> ((pend & $past(restyle)) == '0)); // R5
  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != '0) |=> ((~pend & $past(pend & ~clr & ~restyle)) == '0)); // R6
endmodule

// File: tb/gpio_irq_detect_test.sv
module gpio_irq_detect_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pin_i = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] irq_o;

  int checks = 0;
  int errors = 0;

  gpio_irq_detect uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {style code, pin before, pin after, expected irq on line 3}
  localparam int NV = 14;
  localparam logic [5:0] VEC [NV] = '{
    {3'd0,1'b0,1'b1,1'b1}, {3'd0,1'b0,1'b0,1'b0}, {3'd0,1'b1,1'b0,1'b1},
    {3'd1,1'b1,1'b0,1'b1}, {3'd1,1'b1,1'b1,1'b0},
    {3'd2,1'b0,1'b1,1'b1}, {3'd2,1'b1,1'b0,1'b0},
    {3'd3,1'b1,1'b0,1'b1}, {3'd3,1'b0,1'b1,1'b0},
    {3'd4,1'b0,1'b1,1'b1}, {3'd4,1'b1,1'b0,1'b1}, {3'd4,1'b1,1'b1,1'b0},
    {3'd5,1'b0,1'b1,1'b0}, {3'd6,1'b1,1'b0,1'b0}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] lo_word(input logic [23:0] base, input int line, input logic [2:0] code);
    logic [23:0] w;
    w = base & ~(24'h7 << (3*line));
    w = w | (24'(code) << (3*line));
    return {8'h00, w};
  endfunction

  initial begin
    logic [31:0] r;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    chk({16'h0, irq_o}, 32'h0, "R7 reset irq");
    rd(2'd0, r); chk(r, 32'h00FF_FFFF, "R7 reset style lo");
    rd(2'd1, r); chk(r, 32'h00FF_FFFF, "R7 reset style hi");
    rd(2'd2, r); chk(r, 32'h0, "R7 reset status");

    // R1 R8: style table on line 3
    for (int v = 0; v < NV; v++) begin
      wr(2'd0, 32'h00FF_FFFF);
      pin_i[3] = VEC[v][2];
      wait_n(4);
      wr(2'd0, lo_word(24'hFF_FFFF, 3, VEC[v][5:3]));
      pin_i[3] = VEC[v][1];
      wait_n(3);
      chk({31'h0, irq_o[3]}, {31'h0, VEC[v][0]}, "R1 R8 style vector");
    end
    wr(2'd0, 32'h00FF_FFFF);
    pin_i = '0;
    wait_n(4);
    wr(2'd2, 32'hFFFF);

    // R2 R6 R3: rising edge on line 12 in the upper register
    wr(2'd1, 32'h00FF_AFFF);
    rd(2'd1, r); chk(r, 32'h00FF_AFFF, "R2 style hi readback");
    pin_i[12] = 1'b1;
    wait_n(3);
    chk({16'h0, irq_o}, 32'h1000, "R2 line 12 fires");
    pin_i[12] = 1'b0;
    wait_n(3);
    chk({16'h0, irq_o}, 32'h1000, "R6 edge pending sticky");
    wr(2'd2, 32'h0);
    chk({16'h0, irq_o}, 32'h1000, "R3 zero write no effect");
    wr(2'd2, 32'h1000);
    chk({16'h0, irq_o}, 32'h0, "R3 one write clears");

    // R4: level low on line 5, pin held low
    wr(2'd0, 32'h00FC_FFFF);
    wait_n(2);
    chk({31'h0, irq_o[5]}, 32'h1, "R4 level low pending");
    wr(2'd2, 32'h20);
    chk({31'h0, irq_o[5]}, 32'h1, "R4 clear blocked while active");
    pin_i[5] = 1'b1;
    wait_n(3);
    wr(2'd2, 32'h20);
    chk({31'h0, irq_o[5]}, 32'h0, "R4 clear after release");

    // R5 R8: restyle clears pending, code 5 stays silent
    pin_i[5] = 1'b0;
    wait_n(3);
    chk({31'h0, irq_o[5]}, 32'h1, "R5 pending before restyle");
    wr(2'd0, 32'h00FE_FFFF);
    chk({31'h0, irq_o[5]}, 32'h0, "R5 restyle clears");
    pin_i[5] = 1'b1;
    wait_n(3);
    pin_i[5] = 1'b0;
    wait_n(3);
    chk({31'h0, irq_o[5]}, 32'h0, "R8 code 5 disabled");

    // R9 R7: latency and status equals irq
    wr(2'd0, 32'h00FE_FFFA);
    pin_i[0] = 1'b1;
    wait_n(2);
    chk({31'h0, irq_o[0]}, 32'h0, "R9 not yet after two edges");
    wait_n(1);
    chk({31'h0, irq_o[0]}, 32'h1, "R9 visible after three edges");
    rd(2'd2, r);
    chk(r, 32'h1, "R7 status readback");
    chk({16'h0, irq_o}, r, "R7 irq equals status");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule